// File: doc/BRIEF.md
# Multi-Rail Power-Good Sequencer

This block brings up a set of downstream power stages in dependency order and takes them down again in a fixed order. Each rail has a dependency mask naming the rails that must already be enabled and reporting power-good before it may start. Once they all are, a per-rail delay runs and the rail's enable is then raised. A global ok input starts the sequence. Losing the global ok, or losing power-good on any rail that has already reported good, starts an orderly teardown in which one rail at a time is switched off, with a configurable gap between steps.

A fast over-voltage input clears every enable in the same cycle, whatever the sequencing logic is doing. Dependency masks that form a loop are reported as a configuration error, and while the error is present no rail is enabled. After any shutdown the sequence starts again from nothing only after the global ok has been seen low and then high again. A status output gives the lowest-index rail that has not yet reported good, and a done flag is raised once every rail is good.

Top module: `psq_rail_sequencer`

## Requirements
- R1: After reset all enables are low, the done flag is low, the pending index is 0 and, with an acyclic mask, the configuration error is low.
- R2: Bit j of rail i's mask field, at `dep_mask_i[i*N_RAILS+j]`, means rail i needs rail j. Rail i's enable may rise only when every rail in its mask has its enable high and its power-good high.
- R3: While running, a rail with delay D in `hop_dly_i[i*DLY_W +: DLY_W]` raises its enable on the (D+1)-th consecutive clock edge at which its dependencies are met, counting the first such edge. If the dependencies lapse before then, the count restarts.
- R4: While running, global ok low, or power-good low on a rail that has reported good since the start, begins a teardown. No rail is enabled from then on.
- R5: Teardown switches off one rail per step. The first step falls on the edge after the edge that detected the fault, and successive steps are `down_gap_i`+1 cycles apart. Each step removes the highest-index enabled rail that no other enabled rail depends on.
- R6: While `ov_kill_i` is high every enable is low in the same cycle. The enables stay low afterwards until the restart condition of R8 is met.
- R7: When the masks contain a loop, including a rail that depends on itself, `cfg_err_o` is high and every enable is low. Once the masks are acyclic, `cfg_err_o` returns low.
- R8: After a teardown, an over-voltage kill or a configuration error, no enable rises until global ok has been seen low and then high again.
- R9: While running, `pend_idx_o` is the lowest index of a rail that has not yet reported good (0 otherwise). `seq_done_o` is high when the sequencer is running, every rail has reported good and no kill is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_ok_i | input | 1 | Global ok; a rising level starts a sequence |
| ov_kill_i | input | 1 | Fast over-voltage disable |
| pg_i | input | N_RAILS | Per-rail power-good |
| dep_mask_i | input | N_RAILS*N_RAILS | Per-rail dependency masks |
| hop_dly_i | input | N_RAILS*DLY_W | Per-rail enable delay in cycles |
| down_gap_i | input | GAP_W | Extra cycles between teardown steps |
| en_o | output | N_RAILS | Per-rail enable |
| seq_done_o | output | 1 | All rails good |
| pend_idx_o | output | IDX_W | Lowest rail not yet good |
| cfg_err_o | output | 1 | Dependency loop present |

## Verification
Two functions can act on the same cycle. The first pair is an over-voltage kill arriving while the sequencer is mid-bring-up or already done, so that a rail's delay expiry and the kill share an edge. The second pair is a power-good loss arriving while later rails are still counting their delays. The bench raises the kill a fraction of a cycle after a falling edge and checks within the same cycle that all enables are low and the done flag has dropped. It also forces a power-good drop on a middle rail of a chain, then compares the order of rail switch-offs and their spacing against a behavioural model that is checked every clock.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [1:0] {
    PSQ_IDLE = 2'd0,
    PSQ_RUN  = 2'd1,
    PSQ_SHUT = 2'd2,
    PSQ_HOLD = 2'd3
  } psq_state_e;
endpackage

// File: rtl/psq_dag_check.sv
module psq_dag_check #(
  parameter int N_RAILS = 4
) (
  input  logic [N_RAILS*N_RAILS-1:0] dep_mask_i,
  output logic                       loop_o
);
  localparam int NN = N_RAILS * N_RAILS;

  // Transitive closure by repeated relaxation; a set diagonal bit is a loop.
  function automatic logic has_loop(input logic [NN-1:0] m);
    logic [NN-1:0] reach;
    logic [NN-1:0] grow;
    logic          hit;
    reach = m;
    for (int k = 0; k < N_RAILS; k++) begin
      grow = reach;
      for (int i = 0; i < N_RAILS; i++) begin
        for (int j = 0; j < N_RAILS; j++) begin
          if (reach[i*N_RAILS+j]) grow[i*N_RAILS +: N_RAILS] = grow[i*N_RAILS +: N_RAILS] | m[j*N_RAILS +: N_RAILS];
        end
      end
      reach = grow;
    end
    hit = 1'b0;
    for (int i = 0; i < N_RAILS; i++) hit = hit | reach[i*N_RAILS+i];
    return hit;
  endfunction

  assign loop_o = has_loop(dep_mask_i);
endmodule

// File: rtl/psq_hop_timer.sv
module psq_hop_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ready_i,
  input  logic             enabled_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  logic [DLY_W-1:0] cnt_q;

  assign fire_o = run_i & ready_i & ~enabled_i & (cnt_q == dly_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || !ready_i || enabled_i) begin
      cnt_q <= '0;
    end else if (cnt_q != dly_i) begin
      cnt_q <= cnt_q + DLY_W'(1);
    end
  end
endmodule

// File: rtl/psq_teardown_pick.sv
module psq_teardown_pick #(
  parameter int N_RAILS = 4,
  parameter int IDX_W   = 2
) (
  input  logic [N_RAILS-1:0]         en_i,
  input  logic [N_RAILS*N_RAILS-1:0] dep_mask_i,
  output logic [IDX_W-1:0]           victim_o,
  output logic                       any_o
);
  // Highest-index enabled rail with no enabled dependent.
  function automatic logic [IDX_W:0] pick(input logic [N_RAILS-1:0] en,
                                          input logic [N_RAILS*N_RAILS-1:0] m);
    logic [IDX_W:0] res;
    logic           held;
    res = '0;
    for (int i = 0; i < N_RAILS; i++) begin
      held = 1'b0;
      for (int j = 0; j < N_RAILS; j++) held = held | (en[j] & m[j*N_RAILS+i]);
      if (en[i] && !held) res = {1'b1, IDX_W'(i)};
    end
    return res;
  endfunction

  logic [IDX_W:0] pick_w;
  assign pick_w   = pick(en_i, dep_mask_i);
  assign victim_o = pick_w[IDX_W-1:0];
  assign any_o    = pick_w[IDX_W];
endmodule

// File: rtl/psq_rail_sequencer.sv
module psq_rail_sequencer
  import psq_pkg::*;
#(
  parameter int N_RAILS = 4,
  parameter int DLY_W   = 8,
  parameter int GAP_W   = 6,
  localparam int IDX_W  = (N_RAILS > 1) ? $clog2(N_RAILS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sys_ok_i,
  input  logic                       ov_kill_i,
  input  logic [N_RAILS-1:0]         pg_i,
  input  logic [N_RAILS*N_RAILS-1:0] dep_mask_i,
  input  logic [N_RAILS*DLY_W-1:0]   hop_dly_i,
  input  logic [GAP_W-1:0]           down_gap_i,
  output logic [N_RAILS-1:0]         en_o,
  output logic                       seq_done_o,
  output logic [IDX_W-1:0]           pend_idx_o,
  output logic                       cfg_err_o
);
  psq_state_e         state_q;
  logic [N_RAILS-1:0] en_q;
  logic [N_RAILS-1:0] seen_q;
  logic [GAP_W-1:0]   gap_q;

  logic [N_RAILS-1:0] dep_ok_w;
  logic [N_RAILS-1:0] fire_w;
  logic               loop_w;
  logic               kill_w;
  logic               run_w;
  logic               shut_w;
  logic               fault_w;
  logic               hop_run_w;
  logic [IDX_W-1:0]   victim_w;
  logic               victim_vld_w;

  psq_dag_check #(.N_RAILS(N_RAILS)) u_dag (
    .dep_mask_i (dep_mask_i),
    .loop_o     (loop_w)
  );

  assign kill_w    = ov_kill_i | loop_w;
  assign run_w     = (state_q == PSQ_RUN);
  assign shut_w    = (state_q == PSQ_SHUT);
  assign fault_w   = run_w & (~sys_ok_i | (|(seen_q & ~pg_i)));
  assign hop_run_w = run_w & ~fault_w & ~kill_w;

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    assign dep_ok_w[g] = &(~dep_mask_i[g*N_RAILS +: N_RAILS] | (pg_i & en_q));

    psq_hop_timer #(.DLY_W(DLY_W)) u_hop (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (hop_run_w),
      .ready_i   (dep_ok_w[g]),
      .enabled_i (en_q[g]),
      .dly_i     (hop_dly_i[g*DLY_W +: DLY_W]),
      .fire_o    (fire_w[g])
    );
  end

  psq_teardown_pick #(.N_RAILS(N_RAILS), .IDX_W(IDX_W)) u_pick (
    .en_i       (en_q),
    .dep_mask_i (dep_mask_i),
    .victim_o   (victim_w),
    .any_o      (victim_vld_w)
  );

  function automatic logic [IDX_W-1:0] first_clear(input logic [N_RAILS-1:0] s);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = N_RAILS-1; i >= 0; i--) begin
      if (!s[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PSQ_IDLE;
      en_q    <= '0;
      seen_q  <= '0;
      gap_q   <= '0;
    end else if (kill_w) begin
      state_q <= PSQ_HOLD;
      en_q    <= '0;
      seen_q  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        PSQ_IDLE: if (sys_ok_i) state_q <= PSQ_RUN;
        PSQ_HOLD: if (!sys_ok_i) state_q <= PSQ_IDLE;
        PSQ_RUN: begin
          if (fault_w) begin
            state_q <= PSQ_SHUT;
            seen_q  <= '0;
            gap_q   <= '0;
          end else begin
            en_q   <= en_q | fire_w;
            seen_q <= seen_q | (en_q & pg_i);
          end
        end
        PSQ_SHUT: begin
          if (!victim_vld_w) begin
            state_q <= PSQ_HOLD;
          end else if (gap_q == '0) begin
            en_q  <= en_q & ~({{(N_RAILS-1){1'b0}}, 1'b1} << victim_w);
            gap_q <= down_gap_i;
          end else begin
            gap_q <= gap_q - GAP_W'(1);
          end
        end
        default: state_q <= PSQ_IDLE;
      endcase
    end
  end

  assign en_o       = en_q & ~{N_RAILS{kill_w}};
  assign seq_done_o = run_w & (&seen_q) & ~kill_w;
  assign pend_idx_o = (run_w && !(&seen_q)) ? first_clear(seen_q) : '0;
  assign cfg_err_o  = loop_w;
endmodule

// File: rtl/psq_sequencer_chk.sv
module psq_sequencer_chk #(
  parameter int N_RAILS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ov_kill_i,
  input logic [N_RAILS-1:0]         pg_i,
  input logic [N_RAILS*N_RAILS-1:0] dep_mask_i,
  input logic [N_RAILS-1:0]         en_o,
  input logic [N_RAILS-1:0]         en_q,
  input logic                       seq_done_o,
  input logic                       cfg_err_o,
  input logic                       run_w,
  input logic                       shut_w,
  input logic                       kill_w
);
  AST_OV_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_kill_i |-> (en_o == '0)); // R6
  AST_OV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_kill_i |=> (en_q == '0)); // R6
  AST_LOOP_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (en_o == '0)); // R7
  AST_ONE_STEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_w && !kill_w) |=> ($countones($past(en_q) & ~en_q) <= 1)); // R5
  AST_DONE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (&en_o)); // R9
  AST_RISE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> ((en_q & ~$past(en_q)) == '0)); // R8

  for (genvar g = 0; g < N_RAILS; g++) begin : g_dep
    AST_DEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[g]) |-> $past(&(~dep_mask_i[g*N_RAILS +: N_RAILS] | (pg_i & en_q)))); // R2
  end
endmodule

bind psq_rail_sequencer psq_sequencer_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ov_kill_i  (ov_kill_i),
  .pg_i       (pg_i),
  .dep_mask_i (dep_mask_i),
  .en_o       (en_o),
  .en_q       (en_q),
  .seq_done_o (seq_done_o),
  .cfg_err_o  (cfg_err_o),
  .run_w      (run_w),
  .shut_w     (shut_w),
  .kill_w     (kill_w)
);

// File: tb/psq_rail_sequencer_tb_top.sv
`timescale 1ns/1ps
module psq_rail_sequencer_tb_top;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int GW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_ok = 1'b0;
  logic ov = 1'b0;
  logic [N-1:0]    pg = '0;
  logic [N-1:0]    drop = '0;
  logic [N*N-1:0]  dep = '0;
  logic [N*DW-1:0] dly = '0;
  logic [GW-1:0]   gap = '0;
  logic [N-1:0]    en_o;
  logic            done_o;
  logic [1:0]      pend_o;
  logic            cerr_o;

  always #2.5 clk = ~clk;

  psq_rail_sequencer #(.N_RAILS(N), .DLY_W(DW), .GAP_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_ok_i(sys_ok), .ov_kill_i(ov), .pg_i(pg),
    .dep_mask_i(dep), .hop_dly_i(dly), .down_gap_i(gap),
    .en_o(en_o), .seq_done_o(done_o), .pend_idx_o(pend_o), .cfg_err_o(cerr_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mstate = 0;            // 0 idle, 1 run, 2 shut, 3 hold
  bit men[N];
  bit mseen[N];
  int mcnt[N];
  int mgap = 0;
  int lat[N];
  int off_q[$];
  logic [N-1:0] en_prev = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit needs(int i, int j);
    return dep[i*N+j];
  endfunction

  // Peel off rails whose needs are all peeled; anything left sits on a loop.
  function automatic bit m_loop();
    bit gone[N];
    bit blocked;
    foreach (gone[i]) gone[i] = 0;
    for (int pass = 0; pass < N; pass++) begin
      for (int i = 0; i < N; i++) begin
        if (!gone[i]) begin
          blocked = 0;
          for (int j = 0; j < N; j++) if (needs(i, j) && !gone[j]) blocked = 1;
          if (!blocked) gone[i] = 1;
        end
      end
    end
    for (int i = 0; i < N; i++) if (!gone[i]) return 1;
    return 0;
  endfunction

  function automatic int m_victim();
    bit used;
    for (int i = N-1; i >= 0; i--) begin
      if (men[i]) begin
        used = 0;
        for (int j = 0; j < N; j++) if (men[j] && needs(j, i)) used = 1;
        if (!used) return i;
      end
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] m_en_out();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = men[i] && !ov && !m_loop();
    return v;
  endfunction

  function automatic bit m_all_seen();
    for (int i = 0; i < N; i++) if (!mseen[i]) return 0;
    return 1;
  endfunction

  function automatic int m_pend();
    if (mstate != 1) return 0;
    for (int i = 0; i < N; i++) if (!mseen[i]) return i;
    return 0;
  endfunction

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk or negedge rst_n) begin
    bit nen[N];
    bit nseen[N];
    bit fault;
    bit rdy;
    int v;
    if (!rst_n) begin
      mstate = 0; mgap = 0;
      for (int i = 0; i < N; i++) begin men[i] = 0; mseen[i] = 0; mcnt[i] = 0; end
    end else if (ov || m_loop()) begin
      mstate = 3; mgap = 0;
      for (int i = 0; i < N; i++) begin men[i] = 0; mseen[i] = 0; mcnt[i] = 0; end
    end else begin
      case (mstate)
        0: begin
          for (int i = 0; i < N; i++) mcnt[i] = 0;
          if (sys_ok) mstate = 1;
        end
        3: begin
          for (int i = 0; i < N; i++) mcnt[i] = 0;
          if (!sys_ok) mstate = 0;
        end
        1: begin
          fault = !sys_ok;
          for (int i = 0; i < N; i++) if (mseen[i] && !pg[i]) fault = 1;
          if (fault) begin
            mstate = 2; mgap = 0;
            for (int i = 0; i < N; i++) begin mseen[i] = 0; mcnt[i] = 0; end
          end else begin
            for (int i = 0; i < N; i++) begin
              nen[i] = men[i];
              nseen[i] = mseen[i] || (men[i] && pg[i]);
              if (men[i]) mcnt[i] = 0;
              else begin
                rdy = 1;
                for (int j = 0; j < N; j++) if (needs(i, j) && !(men[j] && pg[j])) rdy = 0;
                if (!rdy) mcnt[i] = 0;
                else if (mcnt[i] == int'(dly[i*DW +: DW])) begin nen[i] = 1; mcnt[i] = 0; end
                else mcnt[i]++;
              end
            end
            for (int i = 0; i < N; i++) begin men[i] = nen[i]; mseen[i] = nseen[i]; end
          end
        end
        default: begin
          for (int i = 0; i < N; i++) mcnt[i] = 0;
          v = m_victim();
          if (v < 0) mstate = 3;
          else if (mgap == 0) begin men[v] = 0; mgap = int'(gap); end
          else mgap--;
        end
      endcase
    end
  end

  // Per-cycle comparison, rail plant and watchdog, away from the rising edge.
  always @(negedge clk) begin
    string etag;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (ov) etag = "R6 enables";
      else if (m_loop()) etag = "R7 enables";
      else if (mstate == 2) etag = "R5 enables";
      else if (mstate == 1) etag = "R2 enables";
      else etag = "R8 enables";
      chk(en_o === m_en_out(), etag, int'(en_o), int'(m_en_out()));
      chk(done_o === (mstate == 1 && m_all_seen() && !ov && !m_loop()), "R9 done",
          int'(done_o), int'(mstate == 1 && m_all_seen() && !ov && !m_loop()));
      chk(int'(pend_o) == m_pend(), "R9 pending", int'(pend_o), m_pend());
      chk(cerr_o === m_loop(), "R7 cfg_err", int'(cerr_o), int'(m_loop()));
      for (int i = 0; i < N; i++) if (en_prev[i] && !en_o[i]) off_q.push_back(i);
    end
    en_prev = en_o;
    for (int i = 0; i < N; i++) begin
      if (en_o[i]) begin
        if (lat[i] < 2) lat[i]++;
      end else lat[i] = 0;
      pg[i] = (lat[i] == 2) && !drop[i];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_need(input int i, input logic [N-1:0] bits);
    dep[i*N +: N] = bits;
  endtask

  task automatic wait_done(input int lim);
    int k = 0;
    while (!done_o && k < lim) begin @(negedge clk); k++; end
    #1;
  endtask

  initial begin
    int k;
    for (int i = 0; i < N; i++) lat[i] = 0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(en_o == '0, "R1 reset enables", int'(en_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    chk(pend_o == 2'd0, "R1 reset pending", int'(pend_o), 0);
    chk(cerr_o == 1'b0, "R1 reset cfg_err", int'(cerr_o), 0);

    // Chain 0 -> 1 -> 2, rail 3 needs 1 and 2.
    set_need(1, 4'b0001); set_need(2, 4'b0010); set_need(3, 4'b0110);
    dly = {8'd2, 8'd0, 8'd5, 8'd3};
    gap = 6'd3;
    sys_ok = 1'b1;
    k = 0;
    while (!en_o[0] && k < 50) begin @(negedge clk); k++; end
    chk(k == 5, "R3 delay of rail 0", k, 5);
    wait_done(200);
    chk(done_o == 1'b1, "R9 chain done", int'(done_o), 1);
    chk(pend_o == 2'd0, "R9 pending when done", int'(pend_o), 0);

    // Power-good loss on rail 1.
    off_q.delete();
    drop[1] = 1'b1;
    tick(40);
    chk(en_o == '0, "R4 teardown after PG loss", int'(en_o), 0);
    chk(off_q.size() == 4, "R5 steps taken", off_q.size(), 4);
    if (off_q.size() == 4) begin
      chk(off_q[0] == 3, "R5 first off", off_q[0], 3);
      chk(off_q[1] == 2, "R5 second off", off_q[1], 2);
      chk(off_q[2] == 1, "R5 third off", off_q[2], 1);
      chk(off_q[3] == 0, "R5 last off", off_q[3], 0);
    end
    drop[1] = 1'b0;
    tick(20);
    chk(en_o == '0, "R8 no restart with ok held high", int'(en_o), 0);
    chk(done_o == 1'b0, "R8 no done with ok held high", int'(done_o), 0);
    sys_ok = 1'b0; tick(2); sys_ok = 1'b1;
    wait_done(200);
    chk(done_o == 1'b1, "R8 restart after ok toggle", int'(done_o), 1);

    // Global ok loss, then a parallel pattern.
    sys_ok = 1'b0;
    tick(30);
    chk(en_o == '0, "R4 teardown after ok loss", int'(en_o), 0);
    set_need(1, 4'b0000); set_need(2, 4'b0011); set_need(3, 4'b0001);
    dly = {8'd4, 8'd0, 8'd20, 8'd1};
    gap = 6'd0;
    tick(2);
    sys_ok = 1'b1;
    k = 0;
    while (!pg[0] && k < 50) begin @(negedge clk); k++; end
    #1;
    chk(en_o[2] == 1'b0, "R2 rail 2 waits for rail 1", int'(en_o[2]), 0);
    wait_done(200);
    chk(done_o == 1'b1, "R9 parallel done", int'(done_o), 1);
    ov = 1'b1;
    #0.5;
    chk(en_o == '0, "R6 same-cycle blanking", int'(en_o), 0);
    chk(done_o == 1'b0, "R6 done drops with kill", int'(done_o), 0);
    tick(3);
    ov = 1'b0;
    tick(6);
    chk(en_o == '0, "R6 stays off after kill", int'(en_o), 0);

    // Kill landing mid bring-up.
    sys_ok = 1'b0; tick(2); sys_ok = 1'b1;
    tick(6);
    ov = 1'b1; tick(1); ov = 1'b0;
    tick(10);
    chk(en_o == '0, "R6 kill during bring-up", int'(en_o), 0);

    // Dependency loops.
    sys_ok = 1'b0;
    set_need(1, 4'b0100); set_need(2, 4'b0010);
    tick(2);
    chk(cerr_o == 1'b1, "R7 two-rail loop flagged", int'(cerr_o), 1);
    sys_ok = 1'b1;
    tick(10);
    chk(en_o == '0, "R7 no enable under loop", int'(en_o), 0);
    set_need(1, 4'b0000); set_need(2, 4'b0000); set_need(3, 4'b1000);
    tick(1);
    chk(cerr_o == 1'b1, "R7 self loop flagged", int'(cerr_o), 1);
    set_need(3, 4'b0010);
    tick(1);
    chk(cerr_o == 1'b0, "R7 clears when acyclic", int'(cerr_o), 0);
    sys_ok = 1'b0; tick(2); sys_ok = 1'b1;
    wait_done(200);
    chk(done_o == 1'b1, "R8 restart after loop fixed", int'(done_o), 1);

    // Global ok lost mid bring-up.
    sys_ok = 1'b0; tick(30);
    dly = {8'd10, 8'd10, 8'd10, 8'd10};
    set_need(1, 4'b0001); set_need(2, 4'b0010); set_need(3, 4'b0100);
    sys_ok = 1'b1;
    k = 0;
    while (!en_o[1] && k < 80) begin @(negedge clk); k++; end
    #1;
    sys_ok = 1'b0;
    tick(30);
    chk(en_o == '0, "R4 teardown mid bring-up", int'(en_o), 0);

    tick(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule